// File: doc/BRIEF.md
# Keyed Watchdog Timer With Register Access

This block is a watchdog peripheral reached through a plain register port: a valid strobe, a write flag, a byte offset and 32-bit write and read data. Once software arms it, a down-counter runs from a reload value picked by a 4-bit timeout index. The reload value is a power of two minus one. Software keeps the system alive by writing a fixed 8-bit key to the restart register. Any other value written there does nothing.

When the counter runs out, the block does one of two things, chosen by the response mode. In mode 0 it drives a system reset pulse straight away. In mode 1 the first expiry raises an interrupt and reloads the counter, and a second expiry that arrives while the interrupt is still pending drives the reset pulse. Software acknowledges the interrupt by reading the acknowledge register. The enable bit is sticky: once set, only a hardware reset clears it.

The base exponent of the reload table is a parameter. With the default of 16, the table runs from 0x0000FFFF to 0x7FFFFFFF.

Top module: `wdog_timer`

## Requirements
- R1: The control register sits at offset 0x00, with enable in bit 0, response mode in bit 1 and the 3-bit pulse code in bits 4:2. The timeout index sits in bits 3:0 at offset 0x04. Both registers read back what was written.
- R2: After reset every register reads zero, and both irq and sys_rst are low.
- R3: The reload value is 2^(BASE_EXP+i)-1 for timeout index i. Writing 1 to the enable bit loads the counter, and the first expiry occurs 2^(BASE_EXP+i) cycles after that write.
- R4: While the block is enabled, a write to offset 0x0C whose low byte is 0x76 reloads the counter. The upper bits of that write are not looked at.
- R5: A write to offset 0x0C with any other low byte leaves the counter counting down.
- R6: Writing 0 to the enable bit does not clear it. Only rst_n disarms the block.
- R7: In mode 0, an expiry raises sys_rst on the next cycle.
- R8: sys_rst stays high for exactly 2^(code+1) cycles.
- R9: In mode 1, an expiry with no interrupt pending sets irq and reloads the counter. An expiry while irq is pending raises sys_rst instead.
- R10: Bit 0 of the status register at offset 0x10 shows irq. A read of offset 0x14 clears irq.
- R11: Offset 0x08 returns the live counter, which drops by one every cycle while enabled.
- R12: A new timeout index takes effect only at the next reload. The count already running is not changed.
- R13: Offsets outside the map read as zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe, one access per cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of a read, zero otherwise |
| irq | output | 1 | Pending watchdog interrupt |
| sys_rst | output | 1 | System reset pulse |

## Verification
The design's state shows up at the ports quickly. A counter that loads the wrong value, or misses a decrement, makes the next sys_rst or irq edge arrive early or late by a measurable number of cycles. The counter register also exposes the error at once on a read. A wrong irq state in mode 1 shows within one timeout period: the second expiry either pulses reset when it should not, or fails to. A pulse counter loaded with the wrong length changes the measured width of the very next reset pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam logic [7:0] WD_KEY   = 8'h76;
   localparam logic [7:0] OFF_CTRL = 8'h00;
   localparam logic [7:0] OFF_TMO  = 8'h04;
   localparam logic [7:0] OFF_CNT  = 8'h08;
   localparam logic [7:0] OFF_KICK = 8'h0C;
   localparam logic [7:0] OFF_STAT = 8'h10;
   localparam logic [7:0] OFF_ACK  = 8'h14;

   typedef enum logic [2:0] {
      SEL_CTRL, SEL_TMO, SEL_CNT, SEL_KICK, SEL_STAT, SEL_ACK, SEL_NONE
   } wd_sel_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 4,
   parameter int PCODE_W = 3,
   parameter int CNT_W   = 31
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_valid,
   input  logic               bus_write,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic [CNT_W-1:0]   cnt_val,
   input  logic               irq_pend,
   output logic               en,
   output logic               mode,
   output logic [PCODE_W-1:0] pcode,
   output logic [IDX_W-1:0]   tmo_idx,
   output logic               arm_load,
   output logic               kick,
   output logic               ack_rd,
   output logic [DATA_W-1:0]  bus_rdata
);
   wd_sel_e           sel;
   logic              wr, rd;
   logic [DATA_W-1:0] rmux;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata[DATA_W-1:8];
   assign wr = bus_valid & bus_write;
   assign rd = bus_valid & ~bus_write;

   always_comb begin
      if      (bus_addr == ADDR_W'(OFF_CTRL)) sel = SEL_CTRL;
      else if (bus_addr == ADDR_W'(OFF_TMO))  sel = SEL_TMO;
      else if (bus_addr == ADDR_W'(OFF_CNT))  sel = SEL_CNT;
      else if (bus_addr == ADDR_W'(OFF_KICK)) sel = SEL_KICK;
      else if (bus_addr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
      else if (bus_addr == ADDR_W'(OFF_ACK))  sel = SEL_ACK;
      else                                    sel = SEL_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en      <= 1'b0;
         mode    <= 1'b0;
         pcode   <= '0;
         tmo_idx <= '0;
      end else if (wr) begin
         if (sel == SEL_CTRL) begin
            en    <= en | bus_wdata[0];
            mode  <= bus_wdata[1];
            pcode <= bus_wdata[2 +: PCODE_W];
         end
         if (sel == SEL_TMO) tmo_idx <= bus_wdata[IDX_W-1:0];
      end
   end

   assign arm_load = wr && (sel == SEL_CTRL) && bus_wdata[0] && !en;
   assign kick     = wr && (sel == SEL_KICK) && (bus_wdata[7:0] == WD_KEY) && en;
   assign ack_rd   = rd && (sel == SEL_ACK);

   always_comb begin
      rmux = '0;
      case (sel)
         SEL_CTRL: begin
            rmux[0]             = en;
            rmux[1]             = mode;
            rmux[2 +: PCODE_W]  = pcode;
         end
         SEL_TMO:  rmux[IDX_W-1:0] = tmo_idx;
         SEL_CNT:  rmux[CNT_W-1:0] = cnt_val;
         SEL_STAT: rmux[0]         = irq_pend;
         default:  rmux = '0;
      endcase
   end

   assign bus_rdata = rd ? rmux : '0;
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int IDX_W    = 4,
   parameter int BASE_EXP = 16,
   parameter int CNT_W    = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             load,
   input  logic [IDX_W-1:0] tmo_idx,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   logic [CNT_W:0]   pow2;
   logic [CNT_W:0]   span;
   logic [CNT_W-1:0] reload;

   always_comb begin
      pow2   = {{CNT_W{1'b0}}, 1'b1} << (BASE_EXP + 32'(tmo_idx));
      span   = pow2 - {{CNT_W{1'b0}}, 1'b1};
      reload = span[CNT_W-1:0];
   end

   assign expire = en && !load && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= reload;
      else if (en) begin
         if (cnt == '0)     cnt <= reload;
         else               cnt <= cnt - CNT_W'(1);
      end
   end
endmodule

// File: rtl/wdog_resp.sv
module wdog_resp #(
   parameter int PCODE_W      = 3,
   parameter bit HAS_IRQ_MODE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               expire,
   input  logic               mode,
   input  logic [PCODE_W-1:0] pcode,
   input  logic               ack_rd,
   output logic               irq,
   output logic               sys_rst
);
   localparam int PLS_W = (1 << PCODE_W) + 1;

   logic [PLS_W-1:0] pls;
   logic [PCODE_W:0] shamt;
   logic             fire;

   assign shamt = {1'b0, pcode} + {{PCODE_W{1'b0}}, 1'b1};

   generate
      if (HAS_IRQ_MODE) begin : g_irq
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         irq_q <= 1'b0;
            else if (expire && mode && !irq_q)  irq_q <= 1'b1;
            else if (ack_rd)                    irq_q <= 1'b0;
         end
         assign irq  = irq_q;
         assign fire = expire && (!mode || irq_q);
      end else begin : g_rst_only
         logic unused_in;
         assign unused_in = mode ^ ack_rd;
         assign irq  = 1'b0;
         assign fire = expire;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pls <= '0;
      else if (fire)        pls <= {{(PLS_W-1){1'b0}}, 1'b1} << shamt;
      else if (pls != '0)   pls <= pls - PLS_W'(1);
   end

   assign sys_rst = (pls != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int IDX_W        = 4,
   parameter int BASE_EXP     = 16,
   parameter int PCODE_W      = 3,
   parameter bit HAS_IRQ_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              sys_rst
);
   localparam int CNT_W = BASE_EXP + (1 << IDX_W) - 1;

   generate
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("counter wider than the data port");
      end
      if (ADDR_W < 5 || DATA_W < 8) begin : g_bad_port
         $error("address or data port too narrow for the register map");
      end
      if (PCODE_W + 2 > 8 || PCODE_W < 1) begin : g_bad_pcode
         $error("pulse code field does not fit the control byte");
      end
   endgenerate

   logic               ctrl_en, ctrl_mode, arm_load, kick, ack_rd, expire;
   logic [PCODE_W-1:0] pcode;
   logic [IDX_W-1:0]   tmo_idx;
   logic [CNT_W-1:0]   cnt_q;

   wdog_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
      .PCODE_W(PCODE_W), .CNT_W(CNT_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_val(cnt_q), .irq_pend(irq),
      .en(ctrl_en), .mode(ctrl_mode), .pcode(pcode), .tmo_idx(tmo_idx),
      .arm_load(arm_load), .kick(kick), .ack_rd(ack_rd), .bus_rdata(bus_rdata)
   );

   wdog_count #(
      .IDX_W(IDX_W), .BASE_EXP(BASE_EXP), .CNT_W(CNT_W)
   ) u_count (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en), .load(arm_load | kick),
      .tmo_idx(tmo_idx), .cnt(cnt_q), .expire(expire)
   );

   wdog_resp #(
      .PCODE_W(PCODE_W), .HAS_IRQ_MODE(HAS_IRQ_MODE)
   ) u_resp (
      .clk(clk), .rst_n(rst_n), .expire(expire), .mode(ctrl_mode),
      .pcode(pcode), .ack_rd(ack_rd), .irq(irq), .sys_rst(sys_rst)
   );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
   import wdog_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              en,
   input logic              mode,
   input logic [CNT_W-1:0]  cnt,
   input logic              irq,
   input logic              sys_rst
);
   logic wr_kick, key_ok, rd_ack, unused_hi;

   assign unused_hi = ^bus_wdata[DATA_W-1:8];
   assign wr_kick = bus_valid && bus_write && (bus_addr == ADDR_W'(OFF_KICK));
   assign key_ok  = (bus_wdata[7:0] == WD_KEY);
   assign rd_ack  = bus_valid && !bus_write && (bus_addr == ADDR_W'(OFF_ACK));

   p_enable_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> en);

   p_count_down_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt != '0 && !(wr_kick && key_ok)) |=> (cnt == $past(cnt) - CNT_W'(1)));

   p_bad_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt != '0 && wr_kick && !key_ok) |=> (cnt == $past(cnt) - CNT_W'(1)));

   p_reset_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst) |-> $past(en));

   p_irq_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(mode));

   p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack && irq) |=> !irq);
endmodule

bind wdog_timer wdog_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .en(ctrl_en), .mode(ctrl_mode),
   .cnt(cnt_q), .irq(irq), .sys_rst(sys_rst)
);

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb;
   localparam int BASE = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, sys_rst;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wdog_timer #(.BASE_EXP(BASE)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sys_rst(sys_rst)
   );

   function automatic int exp_period(input int i);
      return 1 << (BASE + i);
   endfunction

   function automatic int exp_width(input int c);
      return 1 << (c + 1);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic wait_rst(output int k);
      k = 0;
      while (!sys_rst && k < 5000) begin @(negedge clk); k++; end
   endtask

   task automatic wait_irq(output int k);
      k = 0;
      while (!irq && k < 5000) begin @(negedge clk); k++; end
   endtask

   task automatic pulse_len(output int w);
      w = 0;
      while (sys_rst && w < 5000) begin @(negedge clk); w++; end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int k, w;
      int unsigned seed;
      seed = $urandom(32'h1DE5);

      // R2: reset state
      do_reset();
      check("R2 irq", {31'b0, irq}, 0);
      check("R2 sys_rst", {31'b0, sys_rst}, 0);
      bus_rd(8'h00, d); check("R2 ctrl", d, 0);
      bus_rd(8'h04, d); check("R2 tmo", d, 0);
      bus_rd(8'h08, d); check("R2 cnt", d, 0);
      bus_rd(8'h10, d); check("R2 stat", d, 0);

      // R1 readback, R13 unmapped
      bus_wr(8'h00, 32'h0000_001E); bus_rd(8'h00, d); check("R1 ctrl", d, 32'h1E);
      bus_wr(8'h04, 32'hFFFF_FFF5); bus_rd(8'h04, d); check("R1 tmo", d, 32'h5);
      bus_rd(8'h18, d); check("R13 read 0x18", d, 0);
      bus_rd(8'h40, d); check("R13 read 0x40", d, 0);
      bus_wr(8'h1C, 32'hFFFF_FFFF); bus_rd(8'h00, d); check("R13 write no effect", d, 32'h1E);
      bus_rd(8'h08, d); check("R13 counter idle", d, 0);

      // R3 R7 R8: mode 0, idx 1, code 2
      do_reset();
      bus_wr(8'h04, 1); bus_wr(8'h00, (2 << 2) | 1);
      wait_rst(k); check("R3 R7 timeout idx1", k, exp_period(1));
      pulse_len(w); check("R8 width code2", w, exp_width(2));

      // R11 live count, R5 wrong key
      do_reset();
      bus_wr(8'h04, 1); bus_wr(8'h00, 1);
      bus_rd(8'h08, d); check("R11 count after arm", d, 31);
      bus_rd(8'h08, d); check("R11 count next", d, 30);
      bus_wr(8'h0C, 32'h0000_0077);
      bus_rd(8'h08, d); check("R5 bad key ignored", d, 28);
      wait_rst(k); check("R5 expiry unchanged", k, 28);

      // R4 restart with key, upper bits don't care
      do_reset();
      bus_wr(8'h04, 1); bus_wr(8'h00, 1);
      repeat (10) @(negedge clk);
      bus_wr(8'h0C, 32'hABCD_0076);
      wait_rst(k); check("R4 restart reloads", k, exp_period(1));

      // R6 sticky enable
      do_reset();
      bus_wr(8'h00, 1); bus_wr(8'h00, 0);
      bus_rd(8'h00, d); check("R6 enable sticky", d, 1);

      // R9 R10 mode 1 second expiry resets
      do_reset();
      bus_wr(8'h00, 3);
      wait_irq(k); check("R9 first expiry irq", k, exp_period(0));
      check("R9 no reset on first", {31'b0, sys_rst}, 0);
      bus_rd(8'h10, d); check("R10 status pending", d, 1);
      wait_rst(k); check("R9 second expiry reset", k, exp_period(0) - 1);

      // R10 ack clears, next expiry only re-raises irq
      do_reset();
      bus_wr(8'h00, 3);
      wait_irq(k);
      bus_rd(8'h14, d);
      check("R10 ack clears irq", {31'b0, irq}, 0);
      wait_irq(k); check("R10 irq again", k, exp_period(0) - 1);
      check("R10 no reset after ack", {31'b0, sys_rst}, 0);

      // R12 new index applies at next reload
      do_reset();
      bus_wr(8'h00, 3); bus_wr(8'h04, 2);
      wait_irq(k); check("R12 old period kept", k, exp_period(0) - 1);
      wait_rst(k); check("R12 new period used", k, exp_period(2));

      // random mix (R3 R8 R9)
      for (int n = 0; n < 12; n++) begin
         int i, c, m;
         i = $urandom_range(0, 3);
         c = $urandom_range(0, i + 2);
         m = $urandom_range(0, 1);
         do_reset();
         bus_wr(8'h04, i);
         bus_wr(8'h00, (c << 2) | (m << 1) | 1);
         if (m == 1) begin
            wait_irq(k); check("R9 rand irq", k, exp_period(i));
         end
         wait_rst(k); check("R3 rand period", k, exp_period(i));
         pulse_len(w); check("R8 rand width", w, exp_width(c));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule